// File: doc/BRIEF.md
# Clustered Bus Interconnect with Break-Switches

This block joins a group of 16-bit processing elements (PEs) through two levels of statically configured buses. PEs are grouped into clusters. Inside a cluster, each local bus is driven by one PE, picked by that bus's driver field. Every PE in the cluster can read any local bus, and a local read arrives one clock after the driver puts the word out. Between clusters, global buses run past every cluster. Each cluster may drive any global bus from one of its PEs. A register stage sits on each cluster's tap of a global bus, so a global read takes two clocks from driver to reader.

Each global bus has a break-switch between every pair of neighbouring clusters. Opening a switch cuts the bus at that point, and the pieces on either side carry separate values at the same time. Each data word travels with a 1-bit control flag, which goes through the same registers as the word. Every PE input is chosen through a multiplexer, so no tristate drivers are used. A segment with more than one enabled driver is reported as a conflict and delivers zero. Configuration is expected to change only while the PEs are idle.

Top module: `cbus_fabric`

## Requirements
- R1: Local bus b of cluster c carries the output word of PE (c*PPC + lbus_src field of (c,b)). A PE can read any of its cluster's NLB local buses.
- R2: A PE input that selects a local bus shows that bus's value one clock edge after the driving PE presents it.
- R3: A PE input that selects a global bus shows the value of its cluster's segment two clock edges after the driving PE presents it.
- R4: gbrk bit g*(NCL-1)+k set to 1 opens the break between clusters k and k+1 on global bus g. Clusters that are not separated by any open break form one segment. Separate segments carry independent values.
- R5: A segment with exactly one enabled driver carries that driver's word. A segment with no driver carries zero. A segment with two or more drivers carries zero, and seg_conflict[g] is 1 while any segment of bus g has two or more drivers.
- R6: The control bit of each PE output follows the same path and latency as its data word, and appears on pe_cin.
- R7: While rst_n is low, every pe_din and pe_cin bit is zero after the next clock edge.
- R8: The in_sel field of PE p is bits [p*SELW +: SELW]. Its top bit selects global (1) or local (0), and the low bits give the bus index. A local index of NLB or above gives a zero input.

Top module ports use the parameters NCL (clusters), PPC (PEs per cluster), NLB, NGB and DW. PSW = clog2(PPC) and SELW = 1 + clog2(max(NLB,NGB)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pe_dout | input | NCL*PPC*DW | Data word from each PE, PE p at [p*DW +: DW] |
| pe_cout | input | NCL*PPC | Control bit from each PE |
| lbus_src | input | NCL*NLB*PSW | Driver PE of local bus (c,b) at [(c*NLB+b)*PSW +: PSW] |
| gdrv_en | input | NCL*NGB | Cluster c drives global bus g when bit c*NGB+g is 1 |
| gdrv_src | input | NCL*NGB*PSW | PE within cluster c that drives bus g, at [(c*NGB+g)*PSW +: PSW] |
| gbrk | input | NGB*(NCL-1) | Break-switch open bits, per R4 |
| in_sel | input | NCL*PPC*SELW | Input source selection per PE, per R8 |
| pe_din | output | NCL*PPC*DW | Registered data word to each PE |
| pe_cin | output | NCL*PPC | Registered control bit to each PE |
| seg_conflict | output | NGB | Multiple-driver flag per global bus |

## Verification
A wrong break decode or a miscounted driver makes some PE receive a word from the wrong cluster, or a non-zero word where zero is due. seg_conflict shows a bad count at once, and pe_din shows it two edges after the configuration is applied. A missing or extra register on either level shifts the moment a new data word appears by one edge, so each trial changes the data and samples after the first edge and again after the second. A control bit on the wrong stage shows as a mismatch on pe_cin at the same sample points.

// File: rtl/cbus_pkg.sv
// Package: shared source-kind encoding for the clustered bus fabric.
// Assumes: the kind bit is the top bit of each PE's input-select field.
package cbus_pkg;
    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } src_kind_e;
endpackage

// File: rtl/cbus_l1_xbar.sv
// Level-one crossbar for one cluster. Each local bus takes the word of the
// PE named by its driver field. Purely combinational.
// Assumes: the driver field indexes a PE inside the cluster.
module cbus_l1_xbar #(
    parameter int PPC = 4,
    parameter int NLB = 6,
    parameter int WW  = 17,
    parameter int PSW = 2
) (
    input  logic [PPC*WW-1:0]  pe_word,
    input  logic [NLB*PSW-1:0] src,
    output logic [NLB*WW-1:0]  lbus
);
    // Drive each local bus from its selected PE.
    always_comb begin
        lbus = '0;
        for (int b = 0; b < NLB; b++) begin
            for (int k = 0; k < PPC; k++) begin
                if (int'(src[b*PSW +: PSW]) == k)
                    lbus[b*WW +: WW] = pe_word[k*WW +: WW];
            end
        end
    end
endmodule

// File: rtl/cbus_gseg.sv
// Segment resolution for one global bus. For each cluster, this module finds
// the clusters that share its segment, counts their enabled drivers, and gives
// the segment's value as seen by that cluster (zero unless exactly one driver).
// Assumes: NCL >= 2, and brk[k] = 1 opens the bus between clusters k and k+1.
module cbus_gseg #(
    parameter int NCL = 4,
    parameter int PPC = 4,
    parameter int WW  = 17,
    parameter int PSW = 2
) (
    input  logic [NCL*PPC*WW-1:0] pe_word,
    input  logic [NCL-1:0]        drv_en,
    input  logic [NCL*PSW-1:0]    drv_src,
    input  logic [NCL-2:0]        brk,
    output logic [NCL*WW-1:0]     view,
    output logic [NCL-1:0]        clash
);
    // Per cluster: merge drivers inside the reachable segment.
    always_comb begin
        view  = '0;
        clash = '0;
        for (int c = 0; c < NCL; c++) begin
            int          cnt;
            logic [WW-1:0] acc;
            cnt = 0;
            acc = '0;
            for (int j = 0; j < NCL; j++) begin
                logic joined;
                joined = 1'b1;
                for (int k = 0; k < NCL - 1; k++) begin
                    if (brk[k] && ((k >= c && k < j) || (k >= j && k < c)))
                        joined = 1'b0;
                end
                if (joined && drv_en[j]) begin
                    cnt = cnt + 1;
                    for (int s = 0; s < PPC; s++) begin
                        if (int'(drv_src[j*PSW +: PSW]) == s)
                            acc = acc | pe_word[(j*PPC + s)*WW +: WW];
                    end
                end
            end
            if (cnt == 1)
                view[c*WW +: WW] = acc;
            clash[c] = (cnt > 1);
        end
    end
endmodule

// File: rtl/cbus_inmux.sv
// Input port of one PE. It picks a local bus or a registered global tap
// through a multiplexer and registers the result.
// Assumes: synchronous active-low reset; out-of-range local index gives zero.
module cbus_inmux
    import cbus_pkg::*;
#(
    parameter int NLB = 6,
    parameter int NGB = 8,
    parameter int WW  = 17,
    parameter int IW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW:0]       sel,
    input  logic [NLB*WW-1:0] lbus,
    input  logic [NGB*WW-1:0] gview,
    output logic [WW-1:0]     q
);
    logic [WW-1:0] pick;
    logic          live_q;
    src_kind_e     kind;
    logic [IW-1:0] idx;

    assign kind = src_kind_e'(sel[IW]);
    assign idx  = sel[IW-1:0];

    // Select the source word named by the select field.
    always_comb begin
        pick = '0;
        if (kind == SRC_LOCAL) begin
            for (int b = 0; b < NLB; b++)
                if (int'(idx) == b) pick = lbus[b*WW +: WW];
        end else begin
            for (int g = 0; g < NGB; g++)
                if (int'(idx) == g) pick = gview[g*WW +: WW];
        end
    end

    // Register the selected word; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= pick;
    end

    // Track whether the previous edge was out of reset.
    always_ff @(posedge clk) live_q <= rst_n;

    // R7: reset clears the input register.
    a_r7_reset_clear: assert property (@(posedge clk) !rst_n |=> q == '0);

    // R2: a local selection lands one edge after the bus value.
    a_r2_local_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(sel[IW]) == 1'b0 && int'($past(idx)) < NLB)
        |-> q == $past(lbus[int'(idx)*WW +: WW]));
endmodule

// File: rtl/cbus_fabric.sv
// Two-level PE interconnect. It has a local crossbar per cluster, global buses
// cut by break-switches, a register stage on each cluster's global tap, and a
// registered multiplexed input per PE.
// Assumes: configuration inputs change only while the PEs are idle.
module cbus_fabric #(
    parameter int NCL = 4,
    parameter int PPC = 4,
    parameter int NLB = 6,
    parameter int NGB = 8,
    parameter int DW  = 16,
    localparam int NPE  = NCL * PPC,
    localparam int PSW  = (PPC > 1) ? $clog2(PPC) : 1,
    localparam int IW   = $clog2((NLB > NGB) ? NLB : NGB),
    localparam int SELW = IW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPE*DW-1:0]      pe_dout,
    input  logic [NPE-1:0]         pe_cout,
    input  logic [NCL*NLB*PSW-1:0] lbus_src,
    input  logic [NCL*NGB-1:0]     gdrv_en,
    input  logic [NCL*NGB*PSW-1:0] gdrv_src,
    input  logic [NGB*(NCL-1)-1:0] gbrk,
    input  logic [NPE*SELW-1:0]    in_sel,
    output logic [NPE*DW-1:0]      pe_din,
    output logic [NPE-1:0]         pe_cin,
    output logic [NGB-1:0]         seg_conflict
);
    localparam int WW = DW + 1;

    logic [NPE*WW-1:0] pe_word;
    logic [NCL*WW-1:0] segv  [NGB];
    logic [NCL-1:0]    clash [NGB];
    logic [NGB*WW-1:0] gq    [NCL];
    logic              live_q;

    // Pair each PE's control bit with its data word (control at the top).
    always_comb begin
        for (int p = 0; p < NPE; p++)
            pe_word[p*WW +: WW] = {pe_cout[p], pe_dout[p*DW +: DW]};
    end

    // Global buses: gather per-cluster driver settings and resolve segments.
    for (genvar g = 0; g < NGB; g++) begin : g_gbus
        logic [NCL-1:0]     en_g;
        logic [NCL*PSW-1:0] src_g;
        always_comb begin
            for (int c = 0; c < NCL; c++) begin
                en_g[c]              = gdrv_en[c*NGB + g];
                src_g[c*PSW +: PSW]  = gdrv_src[(c*NGB + g)*PSW +: PSW];
            end
        end
        cbus_gseg #(.NCL(NCL), .PPC(PPC), .WW(WW), .PSW(PSW)) u_seg (
            .pe_word (pe_word),
            .drv_en  (en_g),
            .drv_src (src_g),
            .brk     (gbrk[g*(NCL-1) +: NCL-1]),
            .view    (segv[g]),
            .clash   (clash[g])
        );
        assign seg_conflict[g] = |clash[g];
    end

    // Pipeline register on each cluster's tap of every global bus.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NCL; c++)
            for (int g = 0; g < NGB; g++)
                gq[c][g*WW +: WW] <= rst_n ? segv[g][c*WW +: WW] : '0;
    end

    // Track whether the previous edge was out of reset.
    always_ff @(posedge clk) live_q <= rst_n;

    // Clusters: local crossbar plus one input port per PE.
    for (genvar c = 0; c < NCL; c++) begin : g_cl
        logic [NLB*WW-1:0] lbus;
        cbus_l1_xbar #(.PPC(PPC), .NLB(NLB), .WW(WW), .PSW(PSW)) u_xbar (
            .pe_word (pe_word[c*PPC*WW +: PPC*WW]),
            .src     (lbus_src[c*NLB*PSW +: NLB*PSW]),
            .lbus    (lbus)
        );
        for (genvar k = 0; k < PPC; k++) begin : g_pe
            localparam int P = c*PPC + k;
            logic [WW-1:0] q;
            cbus_inmux #(.NLB(NLB), .NGB(NGB), .WW(WW), .IW(IW)) u_in (
                .clk   (clk),
                .rst_n (rst_n),
                .sel   (in_sel[P*SELW +: SELW]),
                .lbus  (lbus),
                .gview (gq[c]),
                .q     (q)
            );
            assign pe_din[P*DW +: DW] = q[DW-1:0];
            assign pe_cin[P]          = q[DW];
        end

        for (genvar g = 0; g < NGB; g++) begin : g_chk
            // R3: the global tap holds the segment value of the previous edge.
            a_r3_global_stage: assert property (@(posedge clk) disable iff (!rst_n)
                live_q |-> gq[c][g*WW +: WW] == $past(segv[g][c*WW +: WW]));
            // R5: a conflicting segment leaves a zero tap.
            a_r5_clash_zero: assert property (@(posedge clk) disable iff (!rst_n)
                clash[g][c] |=> gq[c][g*WW +: WW] == '0);
        end
    end
endmodule

// File: tb/sim_cbus_fabric.sv
`timescale 1ns/1ps
module sim_cbus_fabric;
    localparam int NCL = 4, PPC = 4, NLB = 6, NGB = 8, DW = 16;
    localparam int NPE = NCL*PPC, PSW = 2, SELW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPE*DW-1:0]      pe_dout;
    logic [NPE-1:0]         pe_cout;
    logic [NCL*NLB*PSW-1:0] lbus_src;
    logic [NCL*NGB-1:0]     gdrv_en;
    logic [NCL*NGB*PSW-1:0] gdrv_src;
    logic [NGB*(NCL-1)-1:0] gbrk;
    logic [NPE*SELW-1:0]    in_sel;
    logic [NPE*DW-1:0]      pe_din;
    logic [NPE-1:0]         pe_cin;
    logic [NGB-1:0]         seg_conflict;

    int errors = 0;
    int checks = 0;

    logic [16:0] da [NPE];
    logic [16:0] db [NPE];
    logic [16:0] cur [NPE];
    int   lsrc [NCL][NLB];
    bit   gen  [NCL][NGB];
    int   gsrc [NCL][NGB];
    bit   brk  [NGB][NCL-1];
    int   sel  [NPE];

    always #2 clk = ~clk;

    cbus_fabric #(.NCL(NCL), .PPC(PPC), .NLB(NLB), .NGB(NGB), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .pe_dout(pe_dout), .pe_cout(pe_cout),
        .lbus_src(lbus_src), .gdrv_en(gdrv_en), .gdrv_src(gdrv_src),
        .gbrk(gbrk), .in_sel(in_sel), .pe_din(pe_din), .pe_cin(pe_cin),
        .seg_conflict(seg_conflict)
    );

    // Pack bench arrays onto the ports.
    always_comb begin
        for (int p = 0; p < NPE; p++) begin
            pe_dout[p*DW +: DW]   = cur[p][15:0];
            pe_cout[p]            = cur[p][16];
            in_sel[p*SELW +: SELW] = sel[p][3:0];
        end
        for (int c = 0; c < NCL; c++) begin
            for (int b = 0; b < NLB; b++)
                lbus_src[(c*NLB+b)*PSW +: PSW] = lsrc[c][b][1:0];
            for (int g = 0; g < NGB; g++) begin
                gdrv_en[c*NGB+g]               = gen[c][g];
                gdrv_src[(c*NGB+g)*PSW +: PSW] = gsrc[c][g][1:0];
            end
        end
        for (int g = 0; g < NGB; g++)
            for (int k = 0; k < NCL-1; k++)
                gbrk[g*(NCL-1)+k] = brk[g][k];
    end

    // Number of drivers in cluster c's segment of bus g (walks to the breaks).
    function automatic int seg_drv(int c, int g);
        int lo = c, hi = c, n = 0;
        while (lo > 0 && !brk[g][lo-1]) lo--;
        while (hi < NCL-1 && !brk[g][hi]) hi++;
        for (int j = lo; j <= hi; j++) if (gen[j][g]) n++;
        return n;
    endfunction

    function automatic logic [16:0] seg_val(int c, int g, logic [16:0] d [NPE]);
        int lo = c, hi = c;
        logic [16:0] v = '0;
        if (seg_drv(c, g) != 1) return '0;
        while (lo > 0 && !brk[g][lo-1]) lo--;
        while (hi < NCL-1 && !brk[g][hi]) hi++;
        for (int j = lo; j <= hi; j++) if (gen[j][g]) v = d[j*PPC + gsrc[j][g]];
        return v;
    endfunction

    // Expected registered input: local part from dl, global part from dg.
    function automatic logic [16:0] exp_in(int p, logic [16:0] dl [NPE], logic [16:0] dg [NPE]);
        int c = p / PPC;
        int i = sel[p] % 8;
        if (sel[p] < 8) return (i < NLB) ? dl[c*PPC + lsrc[c][i]] : 17'd0;
        return seg_val(c, i, dg);
    endfunction

    function automatic string tag_of(int p);
        int i = sel[p] % 8;
        if (sel[p] < 8) return (i < NLB) ? "R2" : "R8";
        return (seg_drv(p / PPC, i) == 1) ? "R3" : "R5";
    endfunction

    task automatic chk(string req, int p, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act[15:0] !== exp[15:0]) begin
            errors++;
            $display("FAIL %s pe=%0d data act=%h exp=%h", req, p, act[15:0], exp[15:0]);
        end
        checks++;
        if (act[16] !== exp[16]) begin
            errors++;
            $display("FAIL R6 (%s) pe=%0d ctl act=%b exp=%b", req, p, act[16], exp[16]);
        end
    endtask

    task automatic check_all(string req, logic [16:0] dl [NPE], logic [16:0] dg [NPE]);
        for (int p = 0; p < NPE; p++)
            chk({req, "/", tag_of(p)}, p, {pe_cin[p], pe_din[p*DW +: DW]}, exp_in(p, dl, dg));
    endtask

    task automatic check_conf(string req);
        for (int g = 0; g < NGB; g++) begin
            logic e = 1'b0;
            for (int c = 0; c < NCL; c++) if (seg_drv(c, g) > 1) e = 1'b1;
            checks++;
            if (seg_conflict[g] !== e) begin
                errors++;
                $display("FAIL R5 (%s) conflict bus=%0d act=%b exp=%b", req, g, seg_conflict[g], e);
            end
        end
    endtask

    task automatic rand_data();
        for (int p = 0; p < NPE; p++) begin
            da[p] = 17'($urandom);
            db[p] = 17'($urandom);
        end
    endtask

    // One trial: settle on da, switch to db, sample after edge 1 and edge 2.
    task automatic trial(string req);
        cur = da;
        repeat (3) @(negedge clk);
        check_all(req, da, da);
        check_conf(req);
        cur = db;
        @(negedge clk);
        check_all(req, db, da);
        @(negedge clk);
        check_all(req, db, db);
    endtask

    task automatic rand_cfg();
        for (int c = 0; c < NCL; c++) begin
            for (int b = 0; b < NLB; b++) lsrc[c][b] = $urandom % PPC;
            for (int g = 0; g < NGB; g++) begin
                gen[c][g]  = ($urandom % 4) == 0;
                gsrc[c][g] = $urandom % PPC;
            end
        end
        for (int g = 0; g < NGB; g++)
            for (int k = 0; k < NCL-1; k++) brk[g][k] = ($urandom % 2) == 0;
        for (int p = 0; p < NPE; p++) sel[p] = $urandom % 16;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rand_cfg();
        rand_data();
        cur = da;
        // R7: outputs are zero while reset is held.
        repeat (3) @(negedge clk);
        for (int p = 0; p < NPE; p++)
            chk("R7", p, {pe_cin[p], pe_din[p*DW +: DW]}, 17'd0);
        rst_n = 1'b1;

        // R1: every PE reads a different local bus of its cluster.
        rand_cfg();
        for (int p = 0; p < NPE; p++) sel[p] = p % NLB;
        rand_data();
        trial("R1");

        // R4: all breaks open, each cluster drives bus 0 with its own PE.
        rand_cfg();
        for (int c = 0; c < NCL; c++) begin
            for (int g = 0; g < NGB; g++) gen[c][g] = 1'b0;
            gen[c][0] = 1'b1;
            gsrc[c][0] = c % PPC;
        end
        for (int g = 0; g < NGB; g++)
            for (int k = 0; k < NCL-1; k++) brk[g][k] = 1'b1;
        for (int p = 0; p < NPE; p++) sel[p] = 8;
        rand_data();
        trial("R4");

        // R5: joined bus 1 with two drivers; bus 2 with none.
        for (int g = 0; g < NGB; g++)
            for (int k = 0; k < NCL-1; k++) brk[g][k] = 1'b0;
        for (int c = 0; c < NCL; c++)
            for (int g = 0; g < NGB; g++) gen[c][g] = 1'b0;
        gen[0][1] = 1'b1;
        gen[NCL-1][1] = 1'b1;
        for (int p = 0; p < NPE; p++) sel[p] = (p % 2) ? 9 : 10;
        rand_data();
        trial("R5");

        // R8: local indices past the last local bus read zero.
        for (int p = 0; p < NPE; p++) sel[p] = NLB + (p % 2);
        rand_data();
        trial("R8");

        for (int t = 0; t < 150; t++) begin
            rand_cfg();
            rand_data();
            trial("rand");
        end
        finish_run();
    end
endmodule